// File: doc/BRIEF.md
# Single-Address Microprogram Sequencer

This block steps through a writable control store one microword per clock. It holds the current control-store address in a microprogram counter. By default the next address is that counter plus one, so a plain control word needs no address of its own. A word can instead name one target address. That target is taken always, or only when a chosen status flag holds. A word may also hand control to the start of the routine for the current opcode, which is found by a fixed scaling of the opcode value.

Every word carries a two-bit next-address selector, a flag selector, a polarity bit, one target-address field and a control field. The control field of the word at the current address is driven straight out to the datapath. A write port loads the control store. The write port may be used while reset is held, which lets a microprogram be placed before the sequencer starts running.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is set to address 0, and it stays at 0 for as long as reset is held.
- R2: With the selector at 2'b00 (word bits [1:0]), the next address is the current address plus one.
- R3: Incrementing from the last address (DEPTH-1) wraps the counter to address 0.
- R4: With the selector at 2'b01, the next address is the target field (word bits [10:5]).
- R5: With the selector at 2'b10 and the polarity bit (bit 4) at 0, the target is taken when the flag indexed by bits [3:2] is 1. When that flag is 0, the counter increments.
- R6: With the selector at 2'b10 and the polarity bit at 1, the target is taken when the indexed flag is 0. When that flag is 1, the counter increments.
- R7: With the selector at 2'b11, the next address is `opcode` shifted left by ADDR_W-OPC_W, so opcode 3 gives 12 and opcode 5 gives 20.
- R8: The target field has no effect on the next address when the selector is 2'b00 or 2'b11.
- R9: `ctrl_out` equals word bits [26:11] of the control-store entry at `upc_out`. A word written through the write port is seen at that address from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Instruction opcode used by the map selector |
| flags | input | 4 | Status flags that conditional branches test |
| wr_en | input | 1 | Control-store write enable |
| wr_addr | input | 6 | Control-store write address |
| wr_data | input | 27 | Microword to store |
| ctrl_out | output | 16 | Control field of the current microword |
| upc_out | output | 6 | Current microprogram counter |

## Verification
On every clock, the assertions tie each selector value in the current word to the counter value that follows it. This covers increment, unconditional target, taken and untaken conditional branches in both polarities, opcode map and reset. Some behaviours only the bench scenarios can show. These are whether a whole routine runs in the intended order, whether the wrap from the top address lands on 0, whether junk in an unused target field stays harmless, and whether a rewrite through the write port really appears on the control output.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int NSEL_W = 2;

    typedef enum logic [NSEL_W-1:0] {
        NS_INC = 2'b00,
        NS_JMP = 2'b01,
        NS_CND = 2'b10,
        NS_MAP = 2'b11
    } nsel_e;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 27
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/useq_opmap.sv
module useq_opmap #(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = 6
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int PAD_W = ADDR_W - OPC_W;

    generate
        if (PAD_W > 0) begin : g_scaled
            assign start_addr = {opcode, {PAD_W{1'b0}}};
        end else begin : g_direct
            assign start_addr = opcode;
        end
    endgenerate

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int FLAG_N = 4,
    parameter int COND_W = 2
) (
    input  logic [ADDR_W-1:0] upc,
    input  nsel_e             nsel,
    input  logic [ADDR_W-1:0] target,
    input  logic [COND_W-1:0] csel,
    input  logic              pol,
    input  logic [FLAG_N-1:0] flags,
    input  logic [ADDR_W-1:0] map_addr,
    output logic [ADDR_W-1:0] nxt
);
    logic              taken;
    logic [ADDR_W-1:0] seq_addr;

    always_comb begin
        taken    = flags[csel] ^ pol;
        seq_addr = upc + ADDR_W'(1);
        unique case (nsel)
            NS_INC:  nxt = seq_addr;
            NS_JMP:  nxt = target;
            NS_CND:  nxt = taken ? target : seq_addr;
            NS_MAP:  nxt = map_addr;
            default: nxt = seq_addr;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int CTRL_W     = 16,
    parameter int OPC_W      = 4,
    parameter int FLAG_N     = 4,
    parameter int RESET_ADDR = 0,
    localparam int COND_W    = $clog2(FLAG_N),
    localparam int WORD_W    = CTRL_W + ADDR_W + 1 + COND_W + NSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FLAG_N-1:0] flags,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [ADDR_W-1:0] upc_out
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [ADDR_W-1:0] target;
        logic              pol;
        logic [COND_W-1:0] csel;
        logic [NSEL_W-1:0] nsel;
    } uword_t;

    typedef struct packed {
        logic [ADDR_W-1:0] upc;
    } state_t;

    state_t            st_d, st_q;
    uword_t            cur;
    logic [WORD_W-1:0] raw_word;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] nxt_addr;

    useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (st_q.upc),
        .rd_data (raw_word)
    );

    assign cur = uword_t'(raw_word);

    useq_opmap #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_opmap (
        .opcode     (opcode),
        .start_addr (map_addr)
    );

    useq_nextaddr #(.ADDR_W(ADDR_W), .FLAG_N(FLAG_N), .COND_W(COND_W)) u_next (
        .upc      (st_q.upc),
        .nsel     (nsel_e'(cur.nsel)),
        .target   (cur.target),
        .csel     (cur.csel),
        .pol      (cur.pol),
        .flags    (flags),
        .map_addr (map_addr),
        .nxt      (nxt_addr)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.upc = ADDR_W'(RESET_ADDR);
        end else begin
            st_d.upc = nxt_addr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ctrl_out = cur.ctrl;
    assign upc_out  = st_q.upc;

    // R1: reset holds the counter at its start address
    p_reset_r1: assert property (@(posedge clk)
        rst |=> upc_out == ADDR_W'(RESET_ADDR));

    // R2/R3: sequential step, wrapping modulo depth
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cur.nsel == NS_INC) |=> upc_out == ADDR_W'($past(upc_out) + 1'b1));

    // R4: unconditional target
    p_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (cur.nsel == NS_JMP) |=> upc_out == $past(cur.target));

    // R5/R6: conditional branch taken
    p_cond_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (cur.nsel == NS_CND && (flags[cur.csel] != cur.pol))
        |=> upc_out == $past(cur.target));

    // R5/R6: conditional branch falls through
    p_cond_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (cur.nsel == NS_CND && (flags[cur.csel] == cur.pol))
        |=> upc_out == ADDR_W'($past(upc_out) + 1'b1));

    // R7: opcode map
    p_map_r7: assert property (@(posedge clk) disable iff (rst)
        (cur.nsel == NS_MAP) |=> upc_out == $past(map_addr));

endmodule

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
    import useq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int CTRL_W = 16;
    localparam int OPC_W  = 4;
    localparam int FLAG_N = 4;
    localparam int WORD_W = CTRL_W + ADDR_W + 1 + 2 + 2;
    localparam int NSTEP  = 18;

    // each entry: flags[13:10], opcode[9:6], expected upc[5:0]
    localparam logic [13:0] VEC [NSTEP] = '{
        {4'b0000, 4'd0, 6'd0},   // R2
        {4'b0000, 4'd3, 6'd1},   // R7, R8
        {4'b0010, 4'd0, 6'd12},  // R5 taken
        {4'b0000, 4'd0, 6'd20},  // R6 taken on false
        {4'b0000, 4'd0, 6'd30},  // R4
        {4'b0000, 4'd0, 6'd13},  // R4
        {4'b0000, 4'd0, 6'd40},  // R4
        {4'b0000, 4'd0, 6'd0},
        {4'b0000, 4'd5, 6'd1},   // R7
        {4'b0100, 4'd0, 6'd20},  // R6 fall through
        {4'b0000, 4'd0, 6'd21},  // R8
        {4'b0000, 4'd0, 6'd22},
        {4'b0000, 4'd0, 6'd62},
        {4'b0000, 4'd0, 6'd63},  // R3
        {4'b0000, 4'd0, 6'd0},
        {4'b0000, 4'd3, 6'd1},
        {4'b1101, 4'd0, 6'd12},  // R5 fall through
        {4'b0000, 4'd0, 6'd13}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [OPC_W-1:0]  opcode = '0;
    logic [FLAG_N-1:0] flags = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [CTRL_W-1:0] ctrl_out;
    logic [ADDR_W-1:0] upc_out;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_sequencer uut (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .flags    (flags),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_out (ctrl_out),
        .upc_out  (upc_out)
    );

    function automatic logic [CTRL_W-1:0] ctrl_of(input logic [ADDR_W-1:0] a);
        return 16'hC000 | 16'(a);
    endfunction

    task automatic put(input logic [ADDR_W-1:0] a, input logic [1:0] ns,
                       input logic [ADDR_W-1:0] tgt, input logic [1:0] cs,
                       input logic pl, input logic [CTRL_W-1:0] c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = {c, tgt, pl, cs, ns};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check(input string req, input logic [ADDR_W-1:0] exp_pc,
                         input logic [CTRL_W-1:0] exp_ctrl);
        tests_run++;
        if (upc_out !== exp_pc || ctrl_out !== exp_ctrl) begin
            tests_failed++;
            $display("FAIL %s: upc=%0d ctrl=%h expected upc=%0d ctrl=%h",
                     req, upc_out, ctrl_out, exp_pc, exp_ctrl);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        // fill all words with increments, then place the routine
        for (int a = 0; a < 64; a++) put(6'(a), 2'b00, 6'd0, 2'd0, 1'b0, ctrl_of(6'(a)));
        put(6'd1,  2'b11, 6'h3F, 2'd0, 1'b0, ctrl_of(6'd1));   // map, junk target
        put(6'd12, 2'b10, 6'd20, 2'd1, 1'b0, ctrl_of(6'd12));  // if flag1 -> 20
        put(6'd13, 2'b01, 6'd40, 2'd0, 1'b0, ctrl_of(6'd13));
        put(6'd20, 2'b10, 6'd30, 2'd2, 1'b1, ctrl_of(6'd20));  // if !flag2 -> 30
        put(6'd21, 2'b00, 6'd5,  2'd0, 1'b0, ctrl_of(6'd21));  // junk target
        put(6'd22, 2'b01, 6'd62, 2'd0, 1'b0, ctrl_of(6'd22));
        put(6'd30, 2'b01, 6'd13, 2'd0, 1'b0, ctrl_of(6'd30));
        put(6'd40, 2'b01, 6'd0,  2'd0, 1'b0, ctrl_of(6'd40));

        // R1: still in reset, counter at 0
        @(negedge clk);
        check("R1 reset", 6'd0, ctrl_of(6'd0));
        @(negedge clk);
        rst = 1'b0;

        // R2..R8: walk the routine
        for (int i = 0; i < NSTEP; i++) begin
            flags  = VEC[i][13:10];
            opcode = VEC[i][9:6];
            #1;
            check($sformatf("R2-seq step %0d (R3,R4,R5,R6,R7,R8)", i),
                  VEC[i][5:0], ctrl_of(VEC[i][5:0]));
            @(negedge clk);
        end
        flags = '0;
        opcode = '0;
        #1;
        check("R4 after walk", 6'd40, ctrl_of(6'd40));

        // R1: reset mid-run and hold it
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 6'd0, ctrl_of(6'd0));
        @(negedge clk);
        @(negedge clk);
        check("R1 reset held", 6'd0, ctrl_of(6'd0));

        // R9: rewrite word 0 during reset, new control appears
        put(6'd0, 2'b01, 6'd62, 2'd0, 1'b0, 16'h5A5A);
        #1;
        check("R9 rewrite", 6'd0, 16'h5A5A);
        rst = 1'b0;
        @(negedge clk);
        check("R4 rewritten jump", 6'd62, ctrl_of(6'd62));
        @(negedge clk);
        check("R2 step", 6'd63, ctrl_of(6'd63));
        @(negedge clk);
        check("R3 wrap", 6'd0, 16'h5A5A);

        // R7: highest opcode maps to 60
        rst = 1'b1;
        put(6'd0, 2'b11, 6'd7, 2'd0, 1'b0, 16'h0F0F);
        opcode = 4'd15;
        rst = 1'b0;
        @(negedge clk);
        check("R7 opcode 15", 6'd60, ctrl_of(6'd60));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule